// File: doc/BRIEF.md
# Splittable Lookup-Table Logic Cell

This block is one configurable logic cell of a programmable fabric. Its combinational function comes from a 32-entry, 1-bit truth table held in configuration storage. The five logic inputs index that table. The cell has two internal flip-flops whose outputs feed back as candidate table inputs. A mode bit sets how the table is used. In the single mode it is one function of five variables. In the split mode it is two independent functions of four variables, called F and G. Each of these takes two fixed inputs and two inputs picked by configuration.

Configuration is loaded through a serial shift chain while a load enable is high. The same chain carries the truth table, the mode bit, four source selects and two output selects. Each of the two cell outputs shows, as configured, one of F, G, the F flip-flop or the G flip-flop. This lets every output be either combinational or registered. Both flip-flops run on the one cell clock and share a synchronous reset.

Top module: `slice_clb`

## Requirements
- R1: In single mode (mode bit 0) F equals table entry {E,D,C,B,A}, with A the least significant address bit (lin[0]=A … lin[4]=E).
- R2: In single mode G equals F for every input pattern.
- R3: In split mode (mode bit 1) F equals table entry {0, S1, S0, B, A}. S0 is the source picked by F's first select and S1 is the source picked by F's second select. F therefore reads only entries 0 to 15.
- R4: In split mode G equals table entry {1, T1, T0, B, A}. T0 and T1 are picked by G's two selects, so G reads only entries 16 to 31.
- R5: A 3-bit source select code picks C (0), D (1), E (2), the F flip-flop (3) or the G flip-flop (4). Codes 5 to 7 give constant 0.
- R6: Each output has its own 2-bit select code: 0 shows F, 1 shows G, 2 shows the F flip-flop and 3 shows the G flip-flop.
- R7: On each rising clock edge without reset, the F flip-flop captures F and the G flip-flop captures G. Both use the same clock.
- R8: A synchronous active-high reset clears both flip-flops, whatever F and G are.
- R9: While cfg_en is high, one bit of cfg_in is taken on each rising edge. A load is 49 bits, in this order: table entries 0 to 31, the mode bit, F first select, F second select, G first select, G second select, X output select, Y output select. Each multi-bit field goes least significant bit first. While cfg_en is low, cfg_in has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock for the flip-flops and the configuration chain |
| rst | input | 1 | Synchronous active-high flip-flop reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data |
| lin | input | 5 | Logic inputs, bit 0 = A through bit 4 = E |
| out_x | output | 1 | Configurable output X |
| out_y | output | 1 | Configurable output Y |

## Verification
The bench sweeps all 64 combinations of F's two source selects against all 32 input patterns. This covers the select codes 5 to 7 that must read as zero. A mux that wraps or indexes past the candidate list would show wrong table entries there. Feedback from the flip-flops is checked with a cycle-accurate model of both registers, so a design that feeds back a stale or swapped flip-flop value fails on the next pattern. Reset is tested with an all-ones table, where capture instead of clear would show as a 1. A period of cfg_in toggling with cfg_en low is followed by a full sweep, which catches a chain that shifts when it should not.

// File: rtl/slice_clb_pkg.sv
package slice_clb_pkg;
  localparam int LUT_AW  = 5;
  localparam int LUT_N   = 2 ** LUT_AW;
  localparam int SEL_W   = 3;
  localparam int OSEL_W  = 2;
  localparam int NCAND   = 5;
  localparam int NSEL    = 4;

  // Serial chain: field order is the shift order (first bit ends in bit 0)
  typedef struct packed {
    logic [OSEL_W-1:0] ysel;
    logic [OSEL_W-1:0] xsel;
    logic [SEL_W-1:0]  g_s1;
    logic [SEL_W-1:0]  g_s0;
    logic [SEL_W-1:0]  f_s1;
    logic [SEL_W-1:0]  f_s0;
    logic              split;
    logic [LUT_N-1:0]  truth;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  typedef enum logic [OSEL_W-1:0] {
    OUT_F  = 2'd0,
    OUT_G  = 2'd1,
    OUT_QF = 2'd2,
    OUT_QG = 2'd3
  } out_src_e;
endpackage

// File: rtl/slice_clb_cfg.sv
module slice_clb_cfg #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         cfg_en,
  input  logic         cfg_in,
  output logic [W-1:0] word
);
  // Configuration storage is not reset; it holds until reloaded.
  always_ff @(posedge clk) begin
    if (cfg_en) word <= {cfg_in, word[W-1:1]};
  end
endmodule

// File: rtl/slice_clb_insel.sv
module slice_clb_insel #(
  parameter int SW = 3,
  parameter int NC = 5
) (
  input  logic [SW-1:0] code,
  input  logic [NC-1:0] cand,
  output logic          pick
);
  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (code == k[SW-1:0]) pick = cand[k];
    end
  end
endmodule

// File: rtl/slice_clb_lut.sv
module slice_clb_lut
  import slice_clb_pkg::*;
(
  input  logic [LUT_N-1:0]  truth,
  input  logic              split,
  input  logic [LUT_AW-1:0] lin,
  input  logic [NSEL-1:0]   srcs,   // {g_s1, g_s0, f_s1, f_s0} picked bits
  output logic              f,
  output logic              g
);
  logic [LUT_AW-1:0] adr_full, adr_f, adr_g;

  always_comb begin
    adr_full = lin;
    adr_f    = {1'b0, srcs[1], srcs[0], lin[1], lin[0]};
    adr_g    = {1'b1, srcs[3], srcs[2], lin[1], lin[0]};
    f = truth[split ? adr_f : adr_full];
    g = truth[split ? adr_g : adr_full];
  end
endmodule

// File: rtl/slice_clb.sv
module slice_clb
  import slice_clb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_in,
  input  logic [LUT_AW-1:0] lin,
  output logic              out_x,
  output logic              out_y
);
  logic [CFG_W-1:0] cfg_word;
  cell_cfg_t        cfg;
  logic             f, g, qx, qy;
  logic [NSEL-1:0]  srcs;
  logic [NCAND-1:0] cand;
  logic [SEL_W-1:0] sel_code [NSEL];
  logic             split;
  logic [OSEL_W-1:0] xsel, ysel;

  slice_clb_cfg #(.W(CFG_W)) u_cfg (
    .clk(clk), .cfg_en(cfg_en), .cfg_in(cfg_in), .word(cfg_word)
  );

  assign cfg   = cell_cfg_t'(cfg_word);
  assign split = cfg.split;
  assign xsel  = cfg.xsel;
  assign ysel  = cfg.ysel;
  assign cand  = {qy, qx, lin[4], lin[3], lin[2]};
  assign sel_code[0] = cfg.f_s0;
  assign sel_code[1] = cfg.f_s1;
  assign sel_code[2] = cfg.g_s0;
  assign sel_code[3] = cfg.g_s1;

  for (genvar i = 0; i < NSEL; i++) begin : g_src
    slice_clb_insel #(.SW(SEL_W), .NC(NCAND)) u_sel (
      .code(sel_code[i]), .cand(cand), .pick(srcs[i])
    );
  end

  slice_clb_lut u_lut (
    .truth(cfg.truth), .split(split), .lin(lin), .srcs(srcs), .f(f), .g(g)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else begin
      qx <= f;
      qy <= g;
    end
  end

  function automatic logic route(input logic [OSEL_W-1:0] s,
                                 input logic vf, vg, vqx, vqy);
    case (out_src_e'(s))
      OUT_F:   route = vf;
      OUT_G:   route = vg;
      OUT_QF:  route = vqx;
      default: route = vqy;
    endcase
  endfunction

  assign out_x = route(xsel, f, g, qx, qy);
  assign out_y = route(ysel, f, g, qx, qy);
endmodule

// File: rtl/slice_clb_chk.sv
module slice_clb_chk
  import slice_clb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_in,
  input logic [CFG_W-1:0] cfg_word,
  input logic             split,
  input logic [OSEL_W-1:0] xsel,
  input logic [OSEL_W-1:0] ysel,
  input logic             f,
  input logic             g,
  input logic             qx,
  input logic             qy,
  input logic             out_x,
  input logic             out_y
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_single_mode_R2: assert property (@(posedge clk) disable iff (rst)
    !split |-> (f == g));

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst)) |-> (qx == $past(f) && qy == $past(g)));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (qx == 1'b0 && qy == 1'b0));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_word));

  assert_cfg_shift_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg_word[CFG_W-1] == $past(cfg_in)));

  assert_out_reg_x_R6: assert property (@(posedge clk) disable iff (rst)
    (xsel == OUT_QF) |-> (out_x == qx));

  assert_out_reg_y_R6: assert property (@(posedge clk) disable iff (rst)
    (ysel == OUT_QG) |-> (out_y == qy));
endmodule

bind slice_clb slice_clb_chk u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
  .cfg_word(cfg_word), .split(split), .xsel(xsel), .ysel(ysel),
  .f(f), .g(g), .qx(qx), .qy(qy), .out_x(out_x), .out_y(out_y)
);

// File: tb/slice_clb_tb.sv
module slice_clb_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic [4:0] lin = '0;
  logic out_x, out_y;

  int checks = 0;
  int errors = 0;

  // bench-side configuration model
  logic [31:0] m_t = '0;
  logic        m_sp = 1'b0;
  logic [2:0]  m_f0 = '0, m_f1 = '0, m_g0 = '0, m_g1 = '0;
  logic [1:0]  m_xs = '0, m_ys = '0;
  logic        qxm = 1'b0, qym = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  slice_clb u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .lin(lin), .out_x(out_x), .out_y(out_y)
  );

  function automatic logic src(input logic [2:0] c);
    case (c)
      3'd0: src = lin[2];
      3'd1: src = lin[3];
      3'd2: src = lin[4];
      3'd3: src = qxm;
      3'd4: src = qym;
      default: src = 1'b0;
    endcase
  endfunction

  function automatic logic exp_f();
    int idx;
    if (m_sp) idx = src(m_f1) * 8 + src(m_f0) * 4 + lin[1] * 2 + lin[0];
    else      idx = int'(lin);
    return m_t[idx];
  endfunction

  function automatic logic exp_g();
    int idx;
    if (m_sp) idx = 16 + src(m_g1) * 8 + src(m_g0) * 4 + lin[1] * 2 + lin[0];
    else      idx = int'(lin);
    return m_t[idx];
  endfunction

  function automatic logic exp_out(input logic [1:0] s);
    case (s)
      2'd0: return exp_f();
      2'd1: return exp_g();
      2'd2: return qxm;
      default: return qym;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qxm <= 1'b0;
      qym <= 1'b0;
    end else begin
      qxm <= exp_f();
      qym <= exp_g();
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lin=%0d actual=%0b expected=%0b", tag, lin, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] t, input logic sp,
                      input logic [2:0] f0, f1, g0, g1,
                      input logic [1:0] xs, ys);
    logic [48:0] vec;
    vec = {ys, xs, g1, g0, f1, f0, sp, t};
    for (int i = 0; i < 49; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = vec[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    m_t = t; m_sp = sp; m_f0 = f0; m_f1 = f1; m_g0 = g0; m_g1 = g1;
    m_xs = xs; m_ys = ys;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(input string tx, input string ty, input int passes);
    for (int p = 0; p < passes; p++) begin
      for (int v = 0; v < 32; v++) begin
        @(negedge clk);
        lin = 5'(v);
        #2;
        check(tx, out_x, exp_out(m_xs));
        check(ty, out_y, exp_out(m_ys));
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset clears flip-flops although F and G are 1 (all-ones table)
    lin = 5'd0;
    load(32'hFFFF_FFFF, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd2, 2'd3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #2;
    check("R8 X after reset", out_x, 1'b0);
    check("R8 Y after reset", out_y, 1'b0);
    rst = 1'b0;
    @(negedge clk); #2;
    check("R7 X capture after reset", out_x, 1'b1);
    check("R7 Y capture after reset", out_y, 1'b1);

    // R1/R2: single mode, 5-input AND then an irregular table
    load(32'h8000_0000, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd1);
    sweep("R1 and5 F", "R2 and5 G", 1);
    load(32'h6A5C_93E1, 1'b0, 3'd5, 3'd2, 3'd1, 3'd7, 2'd0, 2'd1);
    sweep("R1 single F", "R2 single G", 1);

    // R3/R4/R5: split mode over all F select pairs
    for (int s0 = 0; s0 < 8; s0++) begin
      for (int s1 = 0; s1 < 8; s1++) begin
        load(32'hC39A_5E17, 1'b1, 3'(s0), 3'(s1), 3'(7 - s0), 3'((s1 + 3) % 8),
             2'd0, 2'd1);
        sweep("R3 R5 split F", "R4 R5 split G", 1);
      end
    end

    // R6/R7: every output select pair, with flip-flop feedback in use
    for (int xs = 0; xs < 4; xs++) begin
      for (int ys = 0; ys < 4; ys++) begin
        load(32'h9D2B_61F4, 1'b1, 3'd3, 3'd4, 3'd4, 3'd3, 2'(xs), 2'(ys));
        sweep("R6 R7 out X", "R6 R7 out Y", 2);
      end
    end
    load(32'h35E8_C0A7, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd2, 2'd3);
    sweep("R7 single QX", "R7 single QY", 2);

    // R9: cfg_in ignored while cfg_en low
    load(32'h1F0E_72D9, 1'b1, 3'd1, 3'd3, 3'd2, 3'd4, 2'd0, 2'd3);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      cfg_in = k[0] ^ k[2];
    end
    sweep("R9 hold X", "R9 hold Y", 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule